// File: doc/BRIEF.md
# Modulo Timer with Status and Control Register

This block is a 16-bit up-counter that returns to zero at a programmable modulo value. A power-of-two prescaler divides the system clock to produce the counter's tick. Software controls the timer through a small byte-wide register bus. The bus has a 3-bit address, separate read and write strobes, and 8-bit write and read data. Through it software sets the modulo value, reads the count, and uses one control and status byte. That byte holds the overflow flag, the interrupt enable, a stop bit, a counter-reset command and the prescaler select.

The counter leaves reset stopped. Software sets the modulo value, clears the stop bit, and then either polls the overflow flag or uses the interrupt request. To acknowledge an overflow, software reads the control byte while the flag is set and then writes a 0 to the flag bit. If an overflow arrives between that read and that write, the flag stays set, so no overflow is lost.

Top module: `mod_timer`

## Requirements
- R1: After reset the control byte reads 0x20 (only the stop bit set). The count reads 0, the modulo reads 0 and `irq` is low.
- R2: The register addresses are: 0 for the control byte, 1 and 2 for the count high and low bytes, and 3 and 4 for the modulo high and low bytes. The modulo bytes are read/write. The count bytes are read-only. Addresses 5 to 7 read 0.
- R3: The control byte has these fields: bit 7 overflow flag, bit 6 interrupt enable, bit 5 stop, bit 4 counter reset, bit 3 reserved, bits 2..0 prescaler select. Bits 4 and 3 always read 0.
- R4: While stop is 1, the count and the prescaler phase hold their values.
- R5: A prescaler select of n gives one tick every 2^n running cycles for n from 0 to 6, counted from a cleared prescaler phase. Select 7 behaves like 6.
- R6: A tick that finds the count equal to the modulo loads the count with 0 and sets the flag. With a modulo of 0, the wrap happens after 0xFFFF.
- R7: Writing the control byte with bit 4 set clears both the count and the prescaler phase.
- R8: A read of the control byte while the flag is set, followed by a write with bit 7 at 0, clears the flag.
- R9: A write of 0 to bit 7 with no arming read before it leaves the flag unchanged. Writing 1 to bit 7 never sets the flag.
- R10: An overflow that occurs between the arming read and the write of 0 makes that write leave the flag set.
- R11: `irq` is high exactly when both the flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume one access per cycle: `rd` and `wr` are never high together, and `addr` and `wdata` hold steady and known for the whole strobe cycle. The bench meets this with a single driver task. That task sets both strobes explicitly on every cycle, issues exactly one read, one write or one idle per cycle, and changes the inputs only just after the rising edge. Tests that depend on the prescaler phase start from a counter-reset write, so each tick count follows from the number of running cycles alone.

// File: rtl/mod_timer.sv
module mod_timer #(
  parameter int PSMAX = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam logic [2:0] PSCAP = 3'(PSMAX);

  logic [15:0]      cnt, modv;
  logic [PSMAX-1:0] pre;
  logic             tof, toie, stop, arm;
  logic [2:0]       ps;

  wire              ctl_wr  = wr && addr == 3'd0;
  wire              ctl_rd  = rd && addr == 3'd0;
  wire              clr_cmd = ctl_wr && wdata[4];
  wire [2:0]        psel    = (ps > PSCAP) ? PSCAP : ps;
  wire [PSMAX-1:0]  pmask   = ~({PSMAX{1'b1}} << psel);
  wire              tick    = !stop && ((pre & pmask) == pmask);
  wire              wrap_pt = (modv == 16'd0) ? (cnt == 16'hFFFF) : (cnt == modv);
  wire              ovf     = tick && wrap_pt && !clr_cmd;

  assign irq = tof & toie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      modv <= '0;
      pre  <= '0;
      tof  <= 1'b0;
      toie <= 1'b0;
      stop <= 1'b1;
      ps   <= '0;
      arm  <= 1'b0;
    end else begin
      if (clr_cmd) begin
        cnt <= '0;
        pre <= '0;
      end else if (!stop) begin
        pre <= pre + 1'b1;
        if (tick) cnt <= wrap_pt ? 16'd0 : cnt + 16'd1;
      end

      if (wr && addr == 3'd3) modv[15:8] <= wdata;
      if (wr && addr == 3'd4) modv[7:0]  <= wdata;

      if (ctl_wr) begin
        toie <= wdata[6];
        stop <= wdata[5];
        ps   <= wdata[2:0];
      end

      if (ovf)                             tof <= 1'b1;
      else if (ctl_wr && !wdata[7] && arm) tof <= 1'b0;

      if (ovf)                         arm <= 1'b0;
      else if (ctl_rd && tof)          arm <= 1'b1;
      else if (ctl_wr && !wdata[7])    arm <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = {tof, toie, stop, 2'b00, ps};
      3'd1:    rdata = cnt[15:8];
      3'd2:    rdata = cnt[7:0];
      3'd3:    rdata = modv[15:8];
      3'd4:    rdata = modv[7:0];
      default: rdata = 8'h00;
    endcase
  end

  assert_stop_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !clr_cmd |=> $stable(cnt) && $stable(pre));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> (cnt == $past(cnt) + 16'd1) || (cnt == 16'd0));

  assert_flag_rise_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tof) |-> cnt == 16'd0);

  assert_flag_clear_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tof) |-> $past(arm && ctl_wr && !wdata[7]));
endmodule

// File: tb/tb_mod_timer.sv
`timescale 1ns/100ps
module tb_mod_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  typedef struct {
    logic [7:0] d;
    logic       i;
    string      req;
  } exp_t;

  exp_t       sb[$];
  int         n_chk = 0, n_bad = 0;
  logic [7:0] cfg = 8'h00;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  mod_timer dut (.clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
                 .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic op(input bit r, input bit w, input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    rd = r; wr = w; addr = a; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) op(1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    op(1'b0, 1'b1, a, d);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input logic ei, input string req);
    exp_t it;
    it.d = e; it.i = ei; it.req = req;
    op(1'b1, 1'b0, a, 8'h00);
    sb.push_back(it);
  endtask

  task automatic run(input int n);
    wr_reg(3'd0, 8'h80 | cfg);
    idle(n - 1);
    wr_reg(3'd0, 8'hA0 | cfg);
  endtask

  always @(negedge clk) begin
    if (rst_n && rd) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none", rdata);
      end else begin
        exp_t it;
        it = sb.pop_front();
        if (rdata !== it.d || irq !== it.i) begin
          n_bad++;
          $display("FAIL %s: addr %0d actual rdata=%h irq=%b expected rdata=%h irq=%b",
                   it.req, addr, rdata, irq, it.d, it.i);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset values, R2 map including unused addresses
    rd_chk(3'd0, 8'h20, 1'b0, "R1");
    rd_chk(3'd1, 8'h00, 1'b0, "R1");
    rd_chk(3'd2, 8'h00, 1'b0, "R1");
    rd_chk(3'd3, 8'h00, 1'b0, "R1");
    rd_chk(3'd4, 8'h00, 1'b0, "R1");
    rd_chk(3'd5, 8'h00, 1'b0, "R2");
    rd_chk(3'd7, 8'h00, 1'b0, "R2");

    // R2 modulo writable, count read-only
    wr_reg(3'd3, 8'h12);
    wr_reg(3'd4, 8'h34);
    rd_chk(3'd3, 8'h12, 1'b0, "R2");
    rd_chk(3'd4, 8'h34, 1'b0, "R2");
    wr_reg(3'd1, 8'hFF);
    rd_chk(3'd1, 8'h00, 1'b0, "R2");

    // R3 field layout, R9 writing 1 to flag does not set it
    wr_reg(3'd0, 8'hFF);
    rd_chk(3'd0, 8'h67, 1'b0, "R3");

    // R5 divide by 1, R4 hold while stopped
    wr_reg(3'd3, 8'h00);
    wr_reg(3'd4, 8'h04);
    cfg = 8'h00;
    wr_reg(3'd0, 8'hB0);
    run(3);
    rd_chk(3'd2, 8'h03, 1'b0, "R5");
    rd_chk(3'd0, 8'h20, 1'b0, "R3");
    idle(5);
    rd_chk(3'd2, 8'h03, 1'b0, "R4");

    // R6 wrap at modulo, R11 irq, R8 clear sequence
    run(2);
    rd_chk(3'd2, 8'h00, 1'b0, "R6");
    wr_reg(3'd0, 8'hE0);
    rd_chk(3'd0, 8'hE0, 1'b1, "R11");
    wr_reg(3'd0, 8'h60);
    rd_chk(3'd0, 8'h60, 1'b0, "R8");

    // R9 write 0 with no arming read
    cfg = 8'h40;
    wr_reg(3'd0, 8'hF0);
    run(5);
    wr_reg(3'd0, 8'h60);
    rd_chk(3'd0, 8'hE0, 1'b1, "R9");

    // R10 overflow between arming read and write of 0
    run(5);
    wr_reg(3'd0, 8'h60);
    rd_chk(3'd0, 8'hE0, 1'b1, "R10");
    wr_reg(3'd0, 8'h60);
    rd_chk(3'd0, 8'h60, 1'b0, "R8");

    // R5 divide by 4, R7 clears count and prescaler phase
    wr_reg(3'd3, 8'h01);
    wr_reg(3'd4, 8'h00);
    cfg = 8'h02;
    wr_reg(3'd0, 8'hB2);
    run(10);
    rd_chk(3'd2, 8'h02, 1'b0, "R5");
    wr_reg(3'd0, 8'hB2);
    rd_chk(3'd2, 8'h00, 1'b0, "R7");
    run(2);
    rd_chk(3'd2, 8'h00, 1'b0, "R7");
    run(2);
    rd_chk(3'd2, 8'h01, 1'b0, "R5");

    // R5 divide by 64 and select 7 behaving as 6
    cfg = 8'h06;
    wr_reg(3'd0, 8'hB6);
    run(130);
    rd_chk(3'd2, 8'h02, 1'b0, "R5");
    cfg = 8'h07;
    wr_reg(3'd0, 8'hB7);
    run(128);
    rd_chk(3'd2, 8'h02, 1'b0, "R5");

    // R6 modulo 0 counts the full range
    wr_reg(3'd3, 8'h00);
    wr_reg(3'd4, 8'h00);
    cfg = 8'h40;
    wr_reg(3'd0, 8'hF0);
    run(65535);
    rd_chk(3'd1, 8'hFF, 1'b0, "R6");
    rd_chk(3'd2, 8'hFF, 1'b0, "R6");
    rd_chk(3'd0, 8'h60, 1'b0, "R6");
    run(1);
    rd_chk(3'd1, 8'h00, 1'b1, "R6");
    rd_chk(3'd2, 8'h00, 1'b1, "R6");
    rd_chk(3'd0, 8'hE0, 1'b1, "R11");

    idle(3);
    if (sb.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule